// File: doc/BRIEF.md
# Serial Flash Command Engine

This block drives single commands to one of up to four serial NOR flash devices over a four-wire serial link. Each bank has its own active-low select. Software sets up the block through a small word-addressed register port: one control word for link timing and modes, one command word that also starts a transfer, a status word, a transmit word and a receive word.

In software mode, a command write with the start bit set shifts out up to four bytes from the transmit word. The engine then clocks in up to four reply bytes and packs them into the receive word. In hardware mode, the same command write can instead run one of two built-in commands on the selected bank. The first reads the flash status byte into the status word. The second sets the flash write-enable latch and records that success in a per-bank bit of the status word.

Completion raises a transfer-finished flag, which can also drive an interrupt. The flash link runs in mode 0 (clock idle low, data sampled on the rising edge). All register and flash pins are plain signals with no handshake. A register write takes effect at the clock edge on which `reg_wr` is high. Reads are combinational from `reg_addr`.

Top module: `sflash_cmd_engine`

## Requirements
- R1: The registers sit at byte offsets 0x00 (control), 0x04 (command), 0x08 (status), 0x0C (transmit) and 0x10 (receive). After reset, control reads 0x0000_020F (all banks enabled, prescaler 2) and every other register and `irq` read 0, with all selects high.
- R2: In software mode (control bit 28 = 1), writing the command word with bit 7 = 1 sends transmit-count bytes (command bits [3:0]) from the transmit word. The least significant byte goes first and each byte goes MSB first, so an erase word {addr[7:0], addr[15:8], addr[23:16], opcode} puts the opcode and then a 24-bit address, high byte first, on the wire. Counts above 4 act as 4.
- R3: After the transmit bytes, receive-count bytes (command bits [6:4]; counts above 4 act as 4) are clocked in. The first received byte lands in receive bits [7:0], and unused upper bytes read zero. The receive word changes only when a software-mode transfer finishes.
- R4: One serial bit lasts P clock cycles, where P is control bits [14:8] (values 0 and 1 act as 2). The clock is low for the first floor(P/2) cycles of each bit and high for the rest. MOSI changes only while the serial clock is low.
- R5: After the last bit, all selects stay high for D+1 bit periods (D = control bits [7:4]), and then status bit 8 (transfer finished) sets. From the command write edge to the flag this takes (8·(tx+rx)+D+1)·P cycles. A transfer of zero bytes never drops a select.
- R6: In hardware mode (control bit 28 = 0), command bit 10 sends opcode 0x05 and places the one reply byte in status bits [7:0]. It takes priority over bit 11, and the start bit 7 has no effect in this mode. In software mode, bits 10 and 11 start nothing.
- R7: In hardware mode, command bit 11 alone sends opcode 0x06 with no reply byte. On completion it sets status bit 12+N for bank N.
- R8: A command aimed at a bank whose enable bit (control bits [3:0]) is clear still runs its timing, but that select stays high. Status bit 11 sets at the start, and no write-enable bit sets.
- R9: A status write keeps only the bits written as 1 (writing 0 clears all flags and the stored status byte).
- R10: `irq` is high while (status bit 8 and command bit 8) or (status bit 9 and command bit 9).
- R11: A command write while a transfer runs starts nothing and leaves the running transfer unchanged.
- R12: At most one select is low at a time, chosen by command bits [13:12].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt, high while an enabled flag is set |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | 4 | Active-low select, one per bank |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Several kinds of internal error show up at the ports, each at a known point. A wrong bit counter or wrong byte index shows on `mosi` within the first byte. It also shows in the receive word as a swapped or misplaced byte as soon as the transfer ends. A wrong phase counter or deselect counter moves the transfer-finished flag off its exact cycle, (8·bytes+D+1)·P cycles after the command write, so the bench measures that latency to the cycle. A wrong latched bank or enable shows on the select lines in the same cycle as the start. The per-bank write-enable bit and the status byte are then read back through the status register in the cycles that follow.

// File: rtl/sfce_pkg.sv
package sfce_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} seq_t;
  typedef enum logic [1:0] {OP_SW, OP_RDSR, OP_WREN} op_t;

  localparam logic [4:0] A_CTL  = 5'h00;
  localparam logic [4:0] A_CMD  = 5'h04;
  localparam logic [4:0] A_STAT = 5'h08;
  localparam logic [4:0] A_TXD  = 5'h0C;
  localparam logic [4:0] A_RXD  = 5'h10;

  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_WREN = 8'h06;

  // command word
  localparam int C_SEND = 7;
  localparam int C_TFIE = 8;
  localparam int C_WCIE = 9;
  localparam int C_HWRS = 10;
  localparam int C_HWWE = 11;
  localparam int C_BANK = 12;
  // control word
  localparam int K_DSEL = 4;
  localparam int K_PRE  = 8;
  localparam int K_SWM  = 28;
  // status word
  localparam int S_TFF  = 8;
  localparam int S_WCF  = 9;
  localparam int S_FAC  = 11;
  localparam int S_WEL0 = 12;
endpackage

// File: rtl/sfce_phase.sv
module sfce_phase #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] div,
  output logic          sck_hi,
  output logic          bit_end
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] per_m1;
  logic [PW-1:0] lo;

  always_comb begin
    per_m1 = (div < PW'(2)) ? PW'(1) : div - PW'(1);
    lo     = PW'((PW+1)'(per_m1) + (PW+1)'(1) >> 1);
  end

  assign sck_hi  = run && (cnt >= lo);
  assign bit_end = run && (cnt == per_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run)          cnt <= '0;
    else if (cnt == per_m1) cnt <= '0;
    else                    cnt <= cnt + PW'(1);
  end
endmodule

// File: rtl/sfce_shifter.sv
module sfce_shifter #(
  parameter int NBYTES = 4,
  localparam int DW = 8 * NBYTES,
  localparam int CW = $clog2(NBYTES + 1),
  localparam int BW = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int IW = BW + 3,
  localparam int KW = BW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [DW-1:0] tx_word,
  input  logic [CW-1:0] n_tx,
  input  logic [CW-1:0] n_rx,
  input  logic          miso,
  output logic          mosi,
  output logic          last_bit,
  output logic [DW-1:0] rx_word
);
  logic [KW-1:0] k;
  logic [KW-1:0] tx_bits;
  logic [KW-1:0] all_bits;
  logic [IW-1:0] j;
  logic [IW-1:0] txi;
  logic [IW-1:0] rxi;
  logic          in_tx;

  always_comb begin
    tx_bits  = KW'({n_tx, 3'b000});
    all_bits = tx_bits + KW'({n_rx, 3'b000});
    in_tx    = k < tx_bits;
    last_bit = (k == all_bits - KW'(1));
    j        = k[IW-1:0] - tx_bits[IW-1:0];
    txi      = {k[IW-1:3], ~k[2:0]};
    rxi      = {j[IW-1:3], ~j[2:0]};
    mosi     = in_tx ? tx_word[txi] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k       <= '0;
      rx_word <= '0;
    end else if (load) begin
      k       <= '0;
      rx_word <= '0;
    end else if (step) begin
      k <= k + KW'(1);
      if (!in_tx) rx_word[rxi] <= miso;
    end
  end
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
  import sfce_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int NBYTES = 4,
  parameter int PRE_W  = 7,
  parameter int DSEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [4:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq,
  output logic             sck,
  output logic [NBANK-1:0] cs_n,
  output logic             mosi,
  input  logic             miso
);
  localparam int BKW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int CW  = $clog2(NBYTES + 1);
  localparam int DW  = 8 * NBYTES;
  localparam int SRW = S_WEL0 + NBANK;
  localparam logic [31:0] CTL_RST = ((32'd1 << NBANK) - 32'd1) | (32'd2 << K_PRE);

  logic [31:0]       ctl_q, cmd_q;
  logic [SRW-1:0]    sr_q, sr_n;
  logic [DW-1:0]     txd_q, rxd_q;
  seq_t              st_q;
  op_t               op_q, l_op;
  logic [BKW-1:0]    bank_q, bank_w;
  logic              ok_q;
  logic [CW-1:0]     ntx_q, nrx_q, l_ntx, l_nrx;
  logic [DW-1:0]     txw_q, l_txw;
  logic [PRE_W-1:0]  div_q;
  logic [DSEL_W-1:0] dsel_q, gap_q;

  logic wr_cmd, wr_sr, go_sw, go_rs, go_we, launch, busy, fin;
  logic sck_hi, bit_end, last_bit, sh_mosi;
  logic [DW-1:0] rx_word;

  function automatic logic [CW-1:0] clamp(input logic [3:0] v);
    return (v > 4'(NBYTES)) ? CW'(NBYTES) : CW'(v);
  endfunction

  assign busy   = (st_q != ST_IDLE);
  assign wr_cmd = reg_wr && (reg_addr == A_CMD);
  assign wr_sr  = reg_wr && (reg_addr == A_STAT);
  assign bank_w = reg_wdata[C_BANK +: BKW];
  assign go_sw  = ctl_q[K_SWM] && reg_wdata[C_SEND];
  assign go_rs  = !ctl_q[K_SWM] && reg_wdata[C_HWRS];
  assign go_we  = !ctl_q[K_SWM] && !reg_wdata[C_HWRS] && reg_wdata[C_HWWE];
  assign launch = wr_cmd && !busy && (go_sw || go_rs || go_we);

  always_comb begin
    l_op  = OP_SW;
    l_ntx = '0;
    l_nrx = '0;
    l_txw = txd_q;
    if (go_sw) begin
      l_ntx = clamp(reg_wdata[3:0]);
      l_nrx = clamp({1'b0, reg_wdata[6:4]});
    end else if (go_rs) begin
      l_op  = OP_RDSR;
      l_ntx = CW'(1);
      l_nrx = CW'(1);
      l_txw = DW'(OPC_RDSR);
    end else if (go_we) begin
      l_op  = OP_WREN;
      l_ntx = CW'(1);
      l_txw = DW'(OPC_WREN);
    end
  end

  sfce_phase #(.PW(PRE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q),
    .sck_hi(sck_hi), .bit_end(bit_end)
  );

  sfce_shifter #(.NBYTES(NBYTES)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(launch), .step(bit_end && st_q == ST_SHIFT),
    .tx_word(txw_q), .n_tx(ntx_q), .n_rx(nrx_q), .miso(miso),
    .mosi(sh_mosi), .last_bit(last_bit), .rx_word(rx_word)
  );

  assign fin  = (st_q == ST_GAP) && bit_end && (gap_q == dsel_q);
  assign sck  = sck_hi && (st_q == ST_SHIFT);
  assign mosi = (st_q == ST_SHIFT) ? sh_mosi : 1'b0;

  for (genvar b = 0; b < NBANK; b++) begin : g_sel
    assign cs_n[b] = !((st_q == ST_SHIFT) && ok_q && (bank_q == BKW'(b)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_SW;
      bank_q <= '0;
      ok_q   <= 1'b0;
      ntx_q  <= '0;
      nrx_q  <= '0;
      txw_q  <= '0;
      div_q  <= '0;
      dsel_q <= '0;
      gap_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch) begin
          st_q   <= (l_ntx == '0 && l_nrx == '0) ? ST_GAP : ST_SHIFT;
          op_q   <= l_op;
          bank_q <= bank_w;
          ok_q   <= ctl_q[bank_w];
          ntx_q  <= l_ntx;
          nrx_q  <= l_nrx;
          txw_q  <= l_txw;
          div_q  <= ctl_q[K_PRE +: PRE_W];
          dsel_q <= ctl_q[K_DSEL +: DSEL_W];
          gap_q  <= '0;
        end
        ST_SHIFT: if (bit_end && last_bit) st_q <= ST_GAP;
        ST_GAP: if (bit_end) begin
          if (gap_q == dsel_q) st_q <= ST_IDLE;
          else                 gap_q <= gap_q + DSEL_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sr_n = sr_q;
    if (wr_sr) sr_n = sr_q & reg_wdata[SRW-1:0];
    if (launch && !ctl_q[bank_w]) sr_n[S_FAC] = 1'b1;
    if (fin) begin
      sr_n[S_TFF] = 1'b1;
      if (op_q == OP_RDSR) sr_n[7:0] = rx_word[7:0];
      if (op_q == OP_WREN && ok_q) sr_n[S_WEL0 + int'(bank_q)] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RST;
      cmd_q <= '0;
      sr_q  <= '0;
      txd_q <= '0;
      rxd_q <= '0;
    end else begin
      sr_q <= sr_n;
      if (reg_wr && reg_addr == A_CTL) ctl_q <= reg_wdata;
      if (wr_cmd)                      cmd_q <= reg_wdata;
      if (reg_wr && reg_addr == A_TXD) txd_q <= reg_wdata[DW-1:0];
      if (fin && op_q == OP_SW)        rxd_q <= rx_word;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = ctl_q;
      A_CMD:   reg_rdata = cmd_q;
      A_STAT:  reg_rdata = 32'(sr_q);
      A_TXD:   reg_rdata = 32'(txd_q);
      A_RXD:   reg_rdata = 32'(rxd_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = (sr_q[S_TFF] && cmd_q[C_TFIE]) || (sr_q[S_WCF] && cmd_q[C_WCIE]);
endmodule

// File: rtl/sfce_checker.sv
module sfce_checker #(
  parameter int NBANK = 4,
  localparam int BKW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] cs_n,
  input logic             sck,
  input logic             mosi,
  input logic             irq,
  input logic             busy,
  input logic             launch,
  input logic             cmd_wr,
  input logic             tff,
  input logic             fac,
  input logic [1:0]       ie,
  input logic [BKW-1:0]   bank
);
  // R12: never more than one select low
  a_r12_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R5: all selects high while idle
  a_r5_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n));

  // R5: finished flag rises only as the engine leaves a transfer
  a_r5_tff_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tff) |-> ($past(busy) && !busy));

  // R4: data stays put while the serial clock is high
  a_r4_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R8: forbidden-access flag rises only on a start
  a_r8_fac_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fac) |-> $past(launch));

  // R11: a command write during a transfer does not retarget it
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(bank));

  // R10: no interrupt while both enables are clear
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == 2'b00) |-> !irq);
endmodule

bind sflash_cmd_engine sfce_checker #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .irq(irq),
  .busy(busy), .launch(launch), .cmd_wr(wr_cmd), .tff(sr_q[8]), .fac(sr_q[11]),
  .ie(cmd_q[9:8]), .bank(bank_q)
);

// File: tb/sflash_cmd_engine_test.sv
`timescale 1ns/1ps

module flash_resp #(parameter int BANK = 0) (
  input  logic        cs_n,
  input  logic        sck,
  input  logic        mosi,
  output logic        miso_o,
  output logic [31:0] first4,
  output logic [7:0]  sreg,
  output int          falls
);
  int         nbits;
  logic [7:0] cur;
  logic [7:0] op;

  function automatic logic [7:0] pat(int n);
    return 8'h5A ^ 8'(BANK * 16) ^ 8'(n * 17);
  endfunction

  function automatic logic [7:0] reply(int n);
    logic [23:0] id;
    id = 24'h1520C2 + 24'(BANK);
    if (n == 0) return pat(0);
    if (op == 8'h05) return sreg;
    if (op == 8'h9F) return (n <= 3) ? id[8*(n-1) +: 8] : 8'h00;
    return pat(n);
  endfunction

  initial begin
    miso_o = 1'b0; first4 = '0; sreg = 8'h00; falls = 0; nbits = 0; cur = 8'h00; op = 8'h00;
  end

  always @(negedge cs_n) begin
    nbits = 0; op = 8'h00; first4 = '0; falls = falls + 1;
    miso_o <= reply(0)[7];
  end

  always @(posedge sck) if (!cs_n) begin
    cur = {cur[6:0], mosi};
    nbits = nbits + 1;
    if (nbits % 8 == 0) begin
      if (nbits <= 32) first4[8*(nbits/8 - 1) +: 8] = cur;
      if (nbits == 8) begin
        op = cur;
        if (cur == 8'h06) sreg = sreg | 8'h02;
      end
    end
  end

  always @(negedge sck) if (!cs_n) miso_o <= reply(nbits / 8)[7 - nbits % 8];
endmodule

module sflash_cmd_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = 5'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        irq, sck, mosi, miso;
  logic [3:0]  cs_n;
  logic [3:0]  fm_miso;
  logic [31:0] fm_rx [4];
  logic [7:0]  fm_sr [4];
  int          fm_falls [4];
  int          nchk = 0;
  int          nfail = 0;
  int          nrise = 0;
  bit          done = 1'b0;

  localparam logic [31:0] SWM = 32'h1000_0000;

  always #10 clk = ~clk;

  sflash_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck(sck),
    .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  flash_resp #(.BANK(0)) fm0 (.cs_n(cs_n[0]), .sck(sck), .mosi(mosi), .miso_o(fm_miso[0]),
    .first4(fm_rx[0]), .sreg(fm_sr[0]), .falls(fm_falls[0]));
  flash_resp #(.BANK(1)) fm1 (.cs_n(cs_n[1]), .sck(sck), .mosi(mosi), .miso_o(fm_miso[1]),
    .first4(fm_rx[1]), .sreg(fm_sr[1]), .falls(fm_falls[1]));
  flash_resp #(.BANK(2)) fm2 (.cs_n(cs_n[2]), .sck(sck), .mosi(mosi), .miso_o(fm_miso[2]),
    .first4(fm_rx[2]), .sreg(fm_sr[2]), .falls(fm_falls[2]));
  flash_resp #(.BANK(3)) fm3 (.cs_n(cs_n[3]), .sck(sck), .mosi(mosi), .miso_o(fm_miso[3]),
    .first4(fm_rx[3]), .sreg(fm_sr[3]), .falls(fm_falls[3]));

  assign miso = |(fm_miso & ~cs_n);

  always @(posedge sck) nrise = nrise + 1;

  function automatic logic [7:0] pat(int b, int n);
    return 8'h5A ^ 8'(b * 16) ^ 8'(n * 17);
  endfunction

  function automatic logic [31:0] ctlw(bit sw, int pre, int dsel, logic [3:0] en);
    return (sw ? SWM : 32'h0) | (32'(pre) << 8) | (32'(dsel) << 4) | 32'(en);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_done(output int cyc);
    logic [31:0] s;
    cyc = 0;
    rd(5'h08, s);
    while (!s[8] && cyc < 20000) begin
      @(posedge clk); cyc++; @(negedge clk);
      rd(5'h08, s);
    end
    if (!s[8]) check(1'b0, "R5 finish timeout", s, 32'h100);
  endtask

  initial begin
    logic [31:0] d, exp, mask;
    int cyc, f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, d); check(d == 32'h0000_020F, "R1 control reset", d, 32'h0000_020F);
    rd(5'h04, d); check(d == 0, "R1 command reset", d, 0);
    rd(5'h08, d); check(d == 0, "R1 status reset", d, 0);
    rd(5'h10, d); check(d == 0, "R1 receive reset", d, 0);
    check(cs_n == 4'hF && !irq, "R1 pins reset", {27'h0, irq, cs_n}, 32'hF);

    // R2 R3 R12 sweep over counts and banks
    wr(5'h00, ctlw(1, 2, 0, 4'hF));
    for (int nt = 0; nt <= 4; nt++)
      for (int nr = 0; nr <= 4; nr++)
        for (int b = 0; b < 4; b++) begin
          logic [31:0] txw;
          int fb;
          txw = {8'h40 + 8'(nr), 8'h30 + 8'(nt), 8'h20 + 8'(b), 8'hA0 | 8'(b)};
          fb = fm_falls[b];
          wr(5'h0C, txw);
          wr(5'h04, (32'(b) << 12) | 32'h80 | (32'(nr) << 4) | 32'(nt));
          wait_done(cyc);
          exp = 0;
          for (int i = 0; i < nr; i++) exp[8*i +: 8] = pat(b, nt + i);
          rd(5'h10, d); check(d == exp, "R3 receive packing", d, exp);
          mask = (nt == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*nt)) - 1);
          check((fm_rx[b] & mask) == (txw & mask), "R2 byte order", fm_rx[b] & mask, txw & mask);
          check(fm_falls[b] == fb + ((nt + nr) > 0 ? 1 : 0), "R12 bank select",
                fm_falls[b], fb + ((nt + nr) > 0 ? 1 : 0));
          rd(5'h08, d); check(d == 32'h100 && !irq, "R10 flag without enable", {irq, d[30:0]}, 32'h100);
          wr(5'h08, 0);
        end

    // R2 R3 count clamp: tx 15 and rx 7 act as 4 and 4
    wr(5'h0C, 32'h1122_33C4);
    wr(5'h04, (32'd1 << 12) | 32'h80 | 32'h70 | 32'hF);
    wait_done(cyc);
    exp = {pat(1, 7), pat(1, 6), pat(1, 5), pat(1, 4)};
    rd(5'h10, d); check(d == exp, "R3 clamp receive", d, exp);
    check(fm_rx[1] == 32'h1122_33C4, "R2 clamp transmit", fm_rx[1], 32'h1122_33C4);
    wr(5'h08, 0);

    // R3 identifier read
    wr(5'h0C, 32'h0000_009F);
    wr(5'h04, (32'd1 << 12) | 32'h80 | 32'h30 | 32'h1);
    wait_done(cyc);
    rd(5'h10, d); check(d == 32'h0015_20C3, "R3 identifier", d, 32'h0015_20C3);
    wr(5'h08, 0);

    // R2 erase word: opcode then address high byte first
    begin
      logic [23:0] ad;
      ad = 24'h12_3456;
      wr(5'h0C, {ad[7:0], ad[15:8], ad[23:16], 8'hD8});
      wr(5'h04, (32'd3 << 12) | 32'h80 | 32'h4);
      wait_done(cyc);
      check(fm_rx[3] == 32'h5634_12D8, "R2 erase order", fm_rx[3], 32'h5634_12D8);
      wr(5'h08, 0);
    end

    // R4 R5 timing, prescaler 5, deselect 3, one byte out, one in
    wr(5'h00, ctlw(1, 5, 3, 4'hF));
    wr(5'h0C, 32'h0000_00B1);
    nrise = 0;
    wr(5'h04, 32'h80 | 32'h10 | 32'h1);
    wait_done(cyc);
    check(cyc == (16 + 4) * 5, "R5 latency P5 D3", cyc, (16 + 4) * 5);
    check(nrise == 16, "R4 clock edges", nrise, 16);
    rd(5'h10, d); check(d == {24'h0, pat(0, 1)}, "R4 sample at P5", d, {24'h0, pat(0, 1)});
    wr(5'h08, 0);

    // R4 odd prescaler 3
    wr(5'h00, ctlw(1, 3, 0, 4'hF));
    wr(5'h04, (32'd2 << 12) | 32'h80 | 32'h20 | 32'h1);
    wait_done(cyc);
    check(cyc == (24 + 1) * 3, "R4 latency P3", cyc, 75);
    rd(5'h10, d); exp = {16'h0, pat(2, 2), pat(2, 1)};
    check(d == exp, "R4 sample at P3", d, exp);
    wr(5'h08, 0);

    // R4 prescaler 0 acts as 2
    wr(5'h00, ctlw(1, 0, 0, 4'hF));
    wr(5'h04, 32'h80 | 32'h1);
    wait_done(cyc);
    check(cyc == (8 + 1) * 2, "R4 prescaler zero", cyc, 18);
    wr(5'h08, 0);

    // R7 write enable in hardware mode, bank 2
    wr(5'h00, ctlw(0, 2, 0, 4'hF));
    wr(5'h04, (32'd2 << 12) | 32'h800);
    wait_done(cyc);
    rd(5'h08, d); check(d == 32'h4100, "R7 write-enable bit", d, 32'h4100);
    check(fm_sr[2] == 8'h02, "R7 opcode reached flash", fm_sr[2], 8'h02);

    // R9 masked status write
    wr(5'h08, 32'h4000);
    rd(5'h08, d); check(d == 32'h4000, "R9 keep written ones", d, 32'h4000);

    // R6 read status, bank 2
    wr(5'h04, (32'd2 << 12) | 32'h400);
    wait_done(cyc);
    rd(5'h08, d); check(d == 32'h4102, "R6 status byte", d, 32'h4102);
    wr(5'h08, 0);

    // R6 priority: read status wins, start bit ignored in hardware mode
    wr(5'h04, (32'd3 << 12) | 32'hC80);
    wait_done(cyc);
    rd(5'h08, d); check(d == 32'h0100, "R6 read-status priority", d, 32'h0100);
    check(fm_sr[3] == 8'h00, "R6 no write enable sent", fm_sr[3], 8'h00);
    wr(5'h08, 0);

    // R6 hardware command bits start nothing in software mode
    wr(5'h00, ctlw(1, 2, 0, 4'hF));
    f0 = fm_falls[0];
    wr(5'h04, 32'h400);
    repeat (100) @(negedge clk);
    rd(5'h08, d); check(d == 0, "R6 ignored in software mode", d, 0);
    check(fm_falls[0] == f0, "R6 no select in software mode", fm_falls[0], f0);

    // R8 disabled bank
    wr(5'h00, ctlw(0, 2, 0, 4'b1011));
    f0 = fm_falls[2];
    wr(5'h04, (32'd2 << 12) | 32'h800);
    wait_done(cyc);
    rd(5'h08, d); check(d == 32'h0900, "R8 forbidden access flag", d, 32'h0900);
    check(fm_falls[2] == f0, "R8 select held high", fm_falls[2], f0);
    wr(5'h08, 0);

    // R10 R9 interrupt follows enabled flag, cleared by zero write
    wr(5'h00, ctlw(1, 2, 0, 4'hF));
    wr(5'h04, 32'h100 | 32'h80 | 32'h1);
    wait_done(cyc);
    check(irq == 1'b1, "R10 irq on finish", irq, 1);
    wr(5'h08, 0);
    rd(5'h08, d);
    check(irq == 1'b0 && d == 0, "R9 zero write clears", {irq, d[30:0]}, 0);

    // R11 start while busy ignored
    wr(5'h00, ctlw(1, 4, 0, 4'hF));
    f0 = fm_falls[1];
    wr(5'h04, 32'h80 | 32'h20);
    wr(5'h04, (32'd1 << 12) | 32'h80 | 32'h40 | 32'h1);
    wait_done(cyc);
    rd(5'h10, d); exp = {16'h0, pat(0, 1), pat(0, 0)};
    check(d == exp, "R11 first transfer kept", d, exp);
    check(fm_falls[1] == f0, "R11 second start dropped", fm_falls[1], f0);
    wr(5'h08, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule